// File: doc/BRIEF.md
# Tile Scroll Address Counter

This block keeps the live 15-bit video address that a tile renderer walks while it draws a frame. The address is a packed record. Bits [4:0] hold the tile column and bits [9:5] hold the tile row. Bits [11:10] hold the two-bit page select, and bits [14:12] hold the pixel row inside a tile. Three strobes from the renderer's timing logic drive the counter. A tile-step strobe moves one tile to the right. A line-end strobe moves down one pixel row and restores the horizontal position. A frame-load strobe copies the whole scroll address that the register side has prepared.

From the live address the block forms three outputs. The first is the 14-bit address of the tile name byte. The second is the 14-bit address of the colour-attribute byte that covers the tile. The third is a two-bit quadrant code that tells the pixel pipeline which 2-bit field of that attribute byte supplies the palette high bits. A render-enable input freezes the counter whenever drawing is off.

Top module: `tile_scroll_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the live address becomes 0. The name address is then 0x2000, the attribute address is 0x23C0 and the quadrant is 0.
- R2: On a tile step with a tile column below 31, the tile column goes up by one and every other field is kept.
- R3: On a tile step with a tile column of 31, the tile column becomes 0 and page bit 10 is inverted. Bit 11 and the vertical fields are kept.
- R4: On a line end, the tile column and page bit 10 are taken from `scroll_temp`. When the pixel row is below 7, it goes up by one and the tile row and bit 11 are kept.
- R5: On a line end with a pixel row of 7, the pixel row becomes 0. If the tile row is neither 29 nor 31, the tile row goes up by one and bit 11 is kept.
- R6: On a line end with a pixel row of 7 and a tile row of 29, the tile row and the pixel row become 0 and page bit 11 is inverted.
- R7: On a line end with a pixel row of 7 and a tile row of 31, the tile row and the pixel row become 0 and bit 11 is not inverted. A tile row of 30 advances to 31 as in R5.
- R8: A frame load copies all 15 bits of `scroll_temp` into the live address. It takes priority over a line end or a tile step in the same cycle.
- R9: `name_addr` is 0x2000 OR live[11:0].
- R10: `attr_addr` is 0x23C0 OR (page << 10) OR ((tile row >> 2) << 3) OR (tile column >> 2).
- R11: `attr_quadrant` bit 0 is bit 1 of the tile column and bit 1 is bit 1 of the tile row. The palette high bits are bits [2q+1:2q] of the attribute byte, where q is the quadrant.
- R12: While `render_en` is low, no strobe changes the live address. This includes a frame load.
- R13: A line end and a tile step in the same cycle act as a line end alone, and the tile step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| render_en | input | 1 | Counter may update when high |
| tile_step | input | 1 | Advance one tile horizontally |
| line_end | input | 1 | End of a visible line: vertical step and horizontal reload |
| frame_load | input | 1 | Copy the whole temp address (pre-render line) |
| scroll_temp | input | 15 | Scroll address prepared by the register side |
| live_addr | output | 15 | Current live address |
| name_addr | output | 14 | Name-byte fetch address |
| attr_addr | output | 14 | Attribute-byte fetch address |
| attr_quadrant | output | 2 | Selects the 2-bit attribute field |

## Verification
Each pattern starts from a known address that a frame load sets up, applies one strobe combination, and compares the result with an address the bench builds from the fields. Tile steps are tried at mid-row and at column 31 with both values of bit 10. This separates a plain carry-free increment from the page-flipping wrap. Line ends are tried with the pixel row below 7, at 7 with an ordinary tile row, and at tile rows 29, 30 and 31. These cases separate the visible-bottom wrap, which flips bit 11, from the out-of-range wrap, which does not, and from a plain step. Further cases show that frame load wins, that a line end beats a tile step, and that render-enable low freezes every strobe. The fetch addresses and the quadrant are compared after every pattern.

// File: rtl/tsc_pkg.sv
// Package: field widths and the packed live-address record for the
// tile scroll counter. Assumes fine row is the most significant field.
package tsc_pkg;
    localparam int COL_W  = 5;                 // tile column / row width
    localparam int PAGE_W = 2;                 // page select width
    localparam int FINE_W = 3;                 // pixel row within tile
    localparam int ADDR_W = FINE_W + PAGE_W + 2 * COL_W;
    localparam int FETCH_W = 14;               // fetch address width
    localparam logic [COL_W-1:0] LAST_ROW = COL_W'(29);

    typedef struct packed {
        logic [FINE_W-1:0] fine;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } vaddr_t;
endpackage

// File: rtl/tsc_horiz.sv
// Horizontal step: one tile to the right; column wrap flips page bit 0.
// Purely combinational; assumes caller decides when to apply it.
module tsc_horiz
    import tsc_pkg::*;
(
    input  vaddr_t cur,
    output vaddr_t nxt
);
    localparam logic [COL_W-1:0] COL_MAX = '1;

    // compute next tile position
    always_comb begin
        nxt = cur;
        if (cur.col == COL_MAX) begin
            nxt.col     = '0;
            nxt.page[0] = ~cur.page[0];
        end else begin
            nxt.col = cur.col + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_vert.sv
// Line-end step: advance pixel row / tile row with the two wrap rules,
// then restore column and page bit 0 from the temp address.
// Purely combinational.
module tsc_vert
    import tsc_pkg::*;
(
    input  vaddr_t cur,
    input  vaddr_t tmp,
    output vaddr_t nxt
);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;
    localparam logic [COL_W-1:0]  ROW_MAX  = '1;

    // vertical advance followed by horizontal reload
    always_comb begin
        nxt = cur;
        if (cur.fine != FINE_MAX) begin
            nxt.fine = cur.fine + 1'b1;
        end else begin
            nxt.fine = '0;
            if (cur.row == LAST_ROW) begin
                nxt.row     = '0;
                nxt.page[1] = ~cur.page[1];
            end else if (cur.row == ROW_MAX) begin
                nxt.row = '0;
            end else begin
                nxt.row = cur.row + 1'b1;
            end
        end
        nxt.col     = tmp.col;
        nxt.page[0] = tmp.page[0];
    end
endmodule

// File: rtl/tsc_decode.sv
// Fetch address decode: name byte, attribute byte and attribute quadrant.
// Assumes the 14-bit fetch space with the name tables at 0x2000.
module tsc_decode
    import tsc_pkg::*;
(
    input  vaddr_t             cur,
    output logic [FETCH_W-1:0] name_addr,
    output logic [FETCH_W-1:0] attr_addr,
    output logic [1:0]         quadrant
);
    localparam logic [FETCH_W-1:0] NAME_BASE = FETCH_W'(14'h2000);
    localparam logic [FETCH_W-1:0] ATTR_BASE = FETCH_W'(14'h23C0);
    localparam int COARSE_SEL = COL_W - 2;     // bits kept after >>2

    // name byte: base plus the low 12 address bits
    always_comb begin
        name_addr = NAME_BASE | FETCH_W'({cur.page, cur.row, cur.col});
    end

    // attribute byte: one byte per 4x4 tile block
    always_comb begin
        attr_addr = ATTR_BASE
                  | (FETCH_W'(cur.page) << 10)
                  | (FETCH_W'(cur.row[COL_W-1 -: COARSE_SEL]) << 3)
                  | FETCH_W'(cur.col[COL_W-1 -: COARSE_SEL]);
    end

    // quadrant within the 4x4 block
    always_comb begin
        quadrant = {cur.row[1], cur.col[1]};
    end
endmodule

// File: rtl/tile_scroll_counter.sv
// Tile scroll address counter: holds the live video address and applies
// frame load > line end > tile step, all gated by render enable.
// Assumes strobes are single-cycle and synchronous to clk.
module tile_scroll_counter
    import tsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                render_en,
    input  logic                tile_step,
    input  logic                line_end,
    input  logic                frame_load,
    input  logic [ADDR_W-1:0]   scroll_temp,
    output logic [ADDR_W-1:0]   live_addr,
    output logic [FETCH_W-1:0]  name_addr,
    output logic [FETCH_W-1:0]  attr_addr,
    output logic [1:0]          attr_quadrant
);
    vaddr_t live_q, tmp, h_nxt, v_nxt;

    assign tmp       = vaddr_t'(scroll_temp);
    assign live_addr = ADDR_W'(live_q);

    tsc_horiz u_horiz (.cur(live_q), .nxt(h_nxt));
    tsc_vert  u_vert  (.cur(live_q), .tmp(tmp), .nxt(v_nxt));
    tsc_decode u_dec  (.cur(live_q), .name_addr(name_addr),
                       .attr_addr(attr_addr), .quadrant(attr_quadrant));

    // live address register with strobe priority
    always_ff @(posedge clk) begin
        if (!rst_n)                     live_q <= '0;
        else if (render_en) begin
            if (frame_load)             live_q <= tmp;
            else if (line_end)          live_q <= v_nxt;
            else if (tile_step)         live_q <= h_nxt;
        end
    end

    assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en |=> $stable(live_addr));

    assert_frame_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && frame_load) |=> (live_addr == $past(scroll_temp)));

    assert_col_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && tile_step && !line_end && !frame_load && live_q.col == '1)
        |=> (live_q.col == '0 && live_q.page[0] != $past(live_q.page[0])));

    assert_row31_no_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && line_end && !frame_load && live_q.fine == '1 && live_q.row == '1)
        |=> (live_q.row == '0 && live_q.page[1] == $past(live_q.page[1])));

    assert_row29_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && line_end && !frame_load && live_q.fine == '1 && live_q.row == LAST_ROW)
        |=> (live_q.row == '0 && live_q.page[1] != $past(live_q.page[1])));

    assert_reload_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && line_end && !frame_load)
        |=> (live_q.col == $past(tmp.col)));
endmodule

// File: tb/tile_scroll_counter_test.sv
// Bench: vector table walked by one loop, then directed reset tests.
module tile_scroll_counter_test;
    logic        clk = 1'b0;
    logic        rst_n, render_en, tile_step, line_end, frame_load;
    logic [14:0] scroll_temp, live_addr;
    logic [13:0] name_addr, attr_addr;
    logic [1:0]  attr_quadrant;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tile_scroll_counter uut (
        .clk(clk), .rst_n(rst_n), .render_en(render_en),
        .tile_step(tile_step), .line_end(line_end), .frame_load(frame_load),
        .scroll_temp(scroll_temp), .live_addr(live_addr),
        .name_addr(name_addr), .attr_addr(attr_addr),
        .attr_quadrant(attr_quadrant));

    function automatic logic [14:0] mk(int f, int p, int r, int c);
        return {f[2:0], p[1:0], r[4:0], c[4:0]};
    endfunction

    // vector: start[48:34] temp[33:19] op[18:16]=F,L,T en[15] expect[14:0]
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {mk(2,0,5,3),   mk(0,0,0,0),   3'b001, 1'b1, mk(2,0,5,4)},
        {mk(1,2,7,31),  mk(0,0,0,0),   3'b001, 1'b1, mk(1,3,7,0)},
        {mk(0,1,0,31),  mk(0,0,0,0),   3'b001, 1'b1, mk(0,0,0,0)},
        {mk(3,2,10,20), mk(5,1,3,9),   3'b010, 1'b1, mk(4,3,10,9)},
        {mk(7,0,10,5),  mk(0,0,0,0),   3'b010, 1'b1, mk(0,0,11,0)},
        {mk(7,1,29,4),  mk(0,0,0,4),   3'b010, 1'b1, mk(0,2,0,4)},
        {mk(7,2,31,0),  mk(0,0,0,0),   3'b010, 1'b1, mk(0,2,0,0)},
        {mk(7,0,30,1),  mk(0,0,0,1),   3'b010, 1'b1, mk(0,0,31,1)},
        {mk(1,1,2,3),   mk(6,3,17,22), 3'b111, 1'b1, mk(6,3,17,22)},
        {mk(2,0,4,31),  mk(0,0,0,31),  3'b011, 1'b1, mk(3,0,4,31)},
        {mk(7,1,29,31), mk(0,0,0,0),   3'b011, 1'b0, mk(7,1,29,31)},
        {mk(4,2,14,6),  mk(1,1,1,1),   3'b100, 1'b0, mk(4,2,14,6)}
    };
    localparam string TAG [NV] = '{"R2","R3","R3","R4","R5","R6",
                                   "R7","R7","R8","R13","R12","R12"};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // outputs derived from the live address (R9, R10, R11)
    task automatic check_fetch(logic [14:0] a);
        logic [13:0] ename, eattr;
        ename = 14'h2000 | {2'b00, a[11:0]};
        eattr = 14'h23C0 | ({12'd0, a[11:10]} << 10)
              | ({11'd0, a[9:7]} << 3) | {11'd0, a[4:2]};
        check("R9",  32'(name_addr), 32'(ename));
        check("R10", 32'(attr_addr), 32'(eattr));
        check("R11", 32'(attr_quadrant), 32'({a[6], a[1]}));
    endtask

    // one clock with the given strobes; returns after the edge settles
    task automatic pulse(logic en, logic f, logic l, logic t, logic [14:0] tmp);
        @(negedge clk);
        render_en = en; frame_load = f; line_end = l; tile_step = t;
        scroll_temp = tmp;
        @(negedge clk);
        frame_load = 1'b0; line_end = 1'b0; tile_step = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; render_en = 1'b0; tile_step = 1'b0;
        line_end = 1'b0; frame_load = 1'b0; scroll_temp = 15'h7FFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 32'(live_addr), 32'd0);
        check_fetch(15'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pulse(1'b1, 1'b1, 1'b0, 1'b0, VEC[i][48:34]);
            pulse(VEC[i][15], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][33:19]);
            check(TAG[i], 32'(live_addr), 32'(VEC[i][14:0]));
            check_fetch(VEC[i][14:0]);
        end

        // R2: a run of steps across a row
        pulse(1'b1, 1'b1, 1'b0, 1'b0, mk(0,0,3,28));
        pulse(1'b1, 1'b0, 1'b0, 1'b1, 15'd0);
        pulse(1'b1, 1'b0, 1'b0, 1'b1, 15'd0);
        check("R2", 32'(live_addr), 32'(mk(0,0,3,30)));
        pulse(1'b1, 1'b0, 1'b0, 1'b1, 15'd0);
        pulse(1'b1, 1'b0, 1'b0, 1'b1, 15'd0);
        check("R3", 32'(live_addr), 32'(mk(0,1,3,0)));
        check_fetch(mk(0,1,3,0));

        // R1: reset in the middle of a run
        pulse(1'b1, 1'b1, 1'b0, 1'b0, mk(5,3,22,13));
        check("R8", 32'(live_addr), 32'(mk(5,3,22,13)));
        @(negedge clk); rst_n = 1'b0; tile_step = 1'b1;
        @(negedge clk); rst_n = 1'b1; tile_step = 1'b0;
        check("R1", 32'(live_addr), 32'd0);
        check_fetch(15'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule